// File: doc/BRIEF.md
# SAR ADC Conversion and Serial Readout Controller

This block is the digital half of a 12-bit successive-approximation converter that is read over a three-wire serial port. While chip-select is high and the block is powered, it keeps the sampler in track. A falling chip-select puts the sampler into hold and starts a binary search. In each step the block drives a trial code to the external binary-weighted DAC and reads a one-bit comparator that reports whether the held input is at or above the trial level. The code left at the end of the search is the unipolar, straight-binary result. Code 0 is ground and the all-ones code is just below the reference.

The host clocks the result out on the serial clock. A frame is three zero bits followed by the 12 result bits, most significant first, and the data line moves only after a rising serial-clock edge. Serial clock, chip-select and the active-low shutdown input are brought into the system clock domain through flop synchronisers, and edges are detected on the synchronised copies. While shutdown is low the block converts nothing and pays no attention to chip-select. The host must allow the conversion time (steps × step cycles, plus synchroniser latency) before its third rising serial-clock edge, because the first result bit appears after that edge.

Top module: `sar_serial_adc_ctrl`

## Requirements
- R1: After reset, with shdn_n high and cs_n high, the block reads track=1, busy=0 and dout_oe=0.
- R2: A synchronised falling edge on cs_n sets track=0 and busy=1. The first trial code is the MSB alone (0x800 for 12 bits).
- R3: Each step keeps the bits already decided and sets the current bit to 1. The bit stays 1 if cmp_ge is 1 (input ≥ trial) and is cleared otherwise. With an ideal comparator, the final dac_code equals the input code.
- R4: busy stays high for exactly RES_BITS × STEP_CYCLES system-clock cycles per conversion (24 with the defaults).
- R5: With chip-select low, the frame bit index k (k = 0 is shown right after the falling edge, and k rises by one on each rising serial-clock edge) shows 0 for k = 0..2 and result bit 14−k for k = 3..14.
- R6: dout changes only in the cycle after a synchronised rising edge of sclk. It does not change in the cycle right after the sclk pin rises.
- R7: After the 15th rising edge (k ≥ 15), dout stays 0 until chip-select goes high.
- R8: Whenever synchronised cs_n is high, dout_oe=0. If cs_n rises mid-frame, the frame is abandoned, the block returns to track, and the next frame starts again from bit 0.
- R9: While shdn_n is low, busy=0, dout_oe=0 and track=0. A cs_n fall during this time starts no conversion.
- R10: After shdn_n returns high, track=1 and the next cs_n falling edge converts normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock from the host, asynchronous |
| cs_n | input | 1 | Active-low chip-select, asynchronous |
| shdn_n | input | 1 | Active-low shutdown, asynchronous |
| cmp_ge | input | 1 | Comparator: 1 when held input ≥ trial level |
| dout | output | 1 | Serial data out |
| dout_oe | output | 1 | Output enable for dout (0 = high impedance) |
| dac_code | output | RES_BITS | Trial code to the DAC; holds the result after a conversion |
| track | output | 1 | 1 = sampler tracks, 0 = hold |
| busy | output | 1 | Conversion in progress |

## Verification
Four properties are checked on every cycle. The data line must not move unless a synchronised serial-clock rise came just before. The output stays disabled while chip-select is high, and the block stays quiet in shutdown. Each conversion opens on the MSB-only trial code, in hold. The bench scenarios are what show that the search lands on the right code for edge-of-range and alternating inputs, that the busy time is exact, and that frame bits arrive in order with a zero tail. They also show that an aborted frame restarts cleanly and that wake-up from shutdown converts again.

// File: rtl/sar_adc_pkg.sv
package sar_adc_pkg;
   typedef enum logic [1:0] {
      ST_SHUT  = 2'd0,
      ST_IDLE  = 2'd1,
      ST_FRAME = 2'd2
   } ctl_state_e;

   localparam int NUM_SYNC = 3;
   localparam int SYNC_SCLK = 0;
   localparam int SYNC_CS = 1;
   localparam int SYNC_SHDN = 2;
endpackage

// File: rtl/sar_sync.sv
module sar_sync #(
   parameter int   STAGES    = 2,
   parameter logic RESET_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= {STAGES{RESET_VAL}};
      else        chain_q <= {chain_q[STAGES-2:0], d};
   end

   assign q = chain_q[STAGES-1];
endmodule

// File: rtl/sar_engine.sv
module sar_engine #(
   parameter int RES_BITS    = 12,
   parameter int STEP_CYCLES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   input  logic                abort,
   input  logic                cmp_ge,
   output logic [RES_BITS-1:0] code,
   output logic                busy
);
   localparam int IW = (RES_BITS > 1) ? $clog2(RES_BITS) : 1;

   logic [RES_BITS-1:0] code_q;
   logic [IW-1:0]       idx_q;
   logic                busy_q;
   logic                step_done;

   generate
      if (STEP_CYCLES > 1) begin : g_step_cnt
         localparam int CW = $clog2(STEP_CYCLES);
         logic [CW-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                   cnt_q <= '0;
            else if (start || !busy_q)    cnt_q <= '0;
            else if (step_done)           cnt_q <= '0;
            else                          cnt_q <= cnt_q + 1'b1;
         end
         assign step_done = busy_q && (cnt_q == CW'(STEP_CYCLES - 1));
      end else begin : g_step_one
         assign step_done = busy_q;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         code_q <= '0;
         idx_q  <= '0;
         busy_q <= 1'b0;
      end else if (abort) begin
         busy_q <= 1'b0;
      end else if (start) begin
         code_q <= {1'b1, {(RES_BITS-1){1'b0}}};
         idx_q  <= IW'(RES_BITS - 1);
         busy_q <= 1'b1;
      end else if (step_done) begin
         if (!cmp_ge) code_q[idx_q] <= 1'b0;
         if (idx_q == '0) begin
            busy_q <= 1'b0;
         end else begin
            code_q[idx_q - 1'b1] <= 1'b1;
            idx_q                <= idx_q - 1'b1;
         end
      end
   end

   assign code = code_q;
   assign busy = busy_q;
endmodule

// File: rtl/sar_frame_shifter.sv
module sar_frame_shifter #(
   parameter int RES_BITS   = 12,
   parameter int LEAD_ZEROS = 3
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                load,
   input  logic                advance,
   input  logic [RES_BITS-1:0] result,
   output logic                dout
);
   localparam int FRAME_BITS = LEAD_ZEROS + RES_BITS;
   localparam int CW = $clog2(FRAME_BITS + 1);

   logic [CW-1:0] pos_q;
   logic          dout_q;
   logic [CW-1:0] pos_nxt;

   function automatic logic frame_bit(input int idx, input logic [RES_BITS-1:0] r);
      if (idx < LEAD_ZEROS)  return 1'b0;
      if (idx < FRAME_BITS)  return r[RES_BITS - 1 - (idx - LEAD_ZEROS)];
      return 1'b0;
   endfunction

   assign pos_nxt = (pos_q == CW'(FRAME_BITS)) ? pos_q : pos_q + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pos_q  <= '0;
         dout_q <= 1'b0;
      end else if (load) begin
         pos_q  <= '0;
         dout_q <= frame_bit(0, result);
      end else if (advance) begin
         pos_q  <= pos_nxt;
         dout_q <= frame_bit(int'(pos_nxt), result);
      end
   end

   assign dout = dout_q;
endmodule

// File: rtl/sar_serial_adc_ctrl.sv
module sar_serial_adc_ctrl
   import sar_adc_pkg::*;
#(
   parameter int RES_BITS    = 12,
   parameter int LEAD_ZEROS  = 3,
   parameter int STEP_CYCLES = 2,
   parameter int SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                sclk,
   input  logic                cs_n,
   input  logic                shdn_n,
   input  logic                cmp_ge,
   output logic                dout,
   output logic                dout_oe,
   output logic [RES_BITS-1:0] dac_code,
   output logic                track,
   output logic                busy
);
   localparam logic [NUM_SYNC-1:0] SYNC_INIT = 3'b010;

   generate
      if (RES_BITS < 2)    begin : g_bad_res   $error("RES_BITS must be at least 2");    end
      if (LEAD_ZEROS < 1)  begin : g_bad_lead  $error("LEAD_ZEROS must be at least 1");  end
      if (STEP_CYCLES < 1) begin : g_bad_step  $error("STEP_CYCLES must be at least 1"); end
      if (SYNC_STAGES < 2) begin : g_bad_sync  $error("SYNC_STAGES must be at least 2"); end
   endgenerate

   logic [NUM_SYNC-1:0] raw_in;
   logic [NUM_SYNC-1:0] sync_out;
   assign raw_in = {shdn_n, cs_n, sclk};

   generate
      for (genvar g = 0; g < NUM_SYNC; g++) begin : g_sync
         sar_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(SYNC_INIT[g])) u_sync (
            .clk(clk), .rst_n(rst_n), .d(raw_in[g]), .q(sync_out[g]));
      end
   endgenerate

   logic sclk_s, cs_s, shdn_s;
   assign sclk_s = sync_out[SYNC_SCLK];
   assign cs_s   = sync_out[SYNC_CS];
   assign shdn_s = sync_out[SYNC_SHDN];

   logic sclk_d, cs_d;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_d <= 1'b0;
         cs_d   <= 1'b1;
      end else begin
         sclk_d <= sclk_s;
         cs_d   <= cs_s;
      end
   end

   logic sclk_rise, cs_fall;
   assign sclk_rise = sclk_s & ~sclk_d;
   assign cs_fall   = cs_d & ~cs_s;

   ctl_state_e state_q, state_d;
   always_comb begin
      state_d = state_q;
      if (!shdn_s) state_d = ST_SHUT;
      else begin
         unique case (state_q)
            ST_SHUT:  state_d = ST_IDLE;
            ST_IDLE:  if (cs_fall) state_d = ST_FRAME;
            ST_FRAME: if (cs_s)    state_d = ST_IDLE;
            default:  state_d = ST_SHUT;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= ST_SHUT;
      else        state_q <= state_d;
   end

   logic start, abort, advance;
   assign start   = (state_q == ST_IDLE) && (state_d == ST_FRAME);
   assign abort   = (state_q == ST_FRAME) && (state_d != ST_FRAME);
   assign advance = (state_q == ST_FRAME) && sclk_rise && !abort;

   sar_engine #(.RES_BITS(RES_BITS), .STEP_CYCLES(STEP_CYCLES)) u_engine (
      .clk(clk), .rst_n(rst_n), .start(start), .abort(abort),
      .cmp_ge(cmp_ge), .code(dac_code), .busy(busy));

   sar_frame_shifter #(.RES_BITS(RES_BITS), .LEAD_ZEROS(LEAD_ZEROS)) u_shift (
      .clk(clk), .rst_n(rst_n), .load(start), .advance(advance),
      .result(dac_code), .dout(dout));

   assign dout_oe = (state_q == ST_FRAME);
   assign track   = (state_q == ST_IDLE);
endmodule

// File: rtl/sar_serial_adc_ctrl_chk.sv
module sar_serial_adc_ctrl_chk #(
   parameter int RES_BITS = 12
) (
   input logic                clk,
   input logic                rst_n,
   input logic                cs_s,
   input logic                shdn_s,
   input logic                sclk_rise,
   input logic                dout,
   input logic                dout_oe,
   input logic [RES_BITS-1:0] dac_code,
   input logic                track,
   input logic                busy
);
   // R6
   dout_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(dout_oe) && dout_oe && !$past(sclk_rise)) |-> $stable(dout));

   // R8
   cs_high_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_s && $past(cs_s)) |-> !dout_oe);

   // R9
   shut_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!shdn_s && !$past(shdn_s)) |-> (!busy && !dout_oe && !track));

   // R2
   first_trial_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> (dac_code == {1'b1, {(RES_BITS-1){1'b0}}} && !track));

   // R2
   hold_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !track);
endmodule

bind sar_serial_adc_ctrl sar_serial_adc_ctrl_chk #(.RES_BITS(RES_BITS)) u_chk (
   .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .shdn_s(shdn_s),
   .sclk_rise(sclk_rise), .dout(dout), .dout_oe(dout_oe),
   .dac_code(dac_code), .track(track), .busy(busy));

// File: tb/sar_serial_adc_ctrl_tb.sv
module sar_serial_adc_ctrl_tb;
   localparam int RES = 12;
   localparam int STEP = 2;
   localparam int HALF = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sclk = 1'b0, cs_n = 1'b1, shdn_n = 1'b1;
   logic [RES-1:0] vin = '0;
   logic cmp_ge, dout, dout_oe, track, busy;
   logic [RES-1:0] dac_code;

   int n_chk = 0, n_bad = 0;
   int busy_cycles = 0;
   logic busy_prev = 1'b0;
   logic [RES-1:0] first_code = '0;
   bit done = 0;

   always #2.5 clk = ~clk;

   assign cmp_ge = (vin >= dac_code);

   sar_serial_adc_ctrl #(.RES_BITS(RES), .LEAD_ZEROS(3), .STEP_CYCLES(STEP), .SYNC_STAGES(2)) u_dut (
      .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .shdn_n(shdn_n),
      .cmp_ge(cmp_ge), .dout(dout), .dout_oe(dout_oe), .dac_code(dac_code),
      .track(track), .busy(busy));

   always @(negedge clk) begin
      if (busy) busy_cycles <= busy_cycles + 1;
      if (busy && !busy_prev) first_code <= dac_code;
      busy_prev <= busy;
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   function automatic logic exp_bit(input int k, input logic [RES-1:0] v);
      if (k < 3) return 1'b0;
      if (k < 15) return v[RES - 1 - (k - 3)];
      return 1'b0;
   endfunction

   task automatic test_reset();
      wait_cyc(10);
      chk(track == 1'b1, "R1 track", int'(track), 1);
      chk(busy == 1'b0, "R1 busy", int'(busy), 0);
      chk(dout_oe == 1'b0, "R1 oe", int'(dout_oe), 0);
   endtask

   task automatic convert_and_check(input logic [RES-1:0] v);
      logic prev;
      vin = v;
      busy_cycles = 0;
      cs_n = 1'b0;
      wait_cyc(6);
      chk(busy == 1'b1, "R2 busy", int'(busy), 1);
      chk(track == 1'b0, "R2 track", int'(track), 0);
      wait_cyc(54);
      chk(first_code == 12'h800, "R2 first trial", int'(first_code), 'h800);
      chk(busy_cycles == RES * STEP, "R4 busy length", busy_cycles, RES * STEP);
      chk(dac_code == v, "R3 result", int'(dac_code), int'(v));
      chk(dout_oe == 1'b1, "R8 oe in frame", int'(dout_oe), 1);
      chk(dout == 1'b0, "R5 bit0", int'(dout), 0);
      for (int k = 1; k <= 17; k++) begin
         prev = dout;
         sclk = 1'b1;
         wait_cyc(1);
         chk(dout == prev, "R6 no early move", int'(dout), int'(prev));
         wait_cyc(HALF - 1);
         sclk = 1'b0;
         wait_cyc(HALF);
         if (k < 15) chk(dout == exp_bit(k, v), "R5 frame bit", int'(dout), int'(exp_bit(k, v)));
         else        chk(dout == 1'b0, "R7 tail zero", int'(dout), 0);
      end
      cs_n = 1'b1;
      wait_cyc(10);
      chk(dout_oe == 1'b0, "R8 oe off", int'(dout_oe), 0);
      chk(track == 1'b1, "R8 back to track", int'(track), 1);
   endtask

   task automatic test_abort();
      vin = 12'hFFF;
      cs_n = 1'b0;
      wait_cyc(60);
      for (int k = 0; k < 5; k++) begin
         sclk = 1'b1; wait_cyc(HALF);
         sclk = 1'b0; wait_cyc(HALF);
      end
      cs_n = 1'b1;
      wait_cyc(10);
      chk(dout_oe == 1'b0, "R8 abort oe", int'(dout_oe), 0);
      chk(track == 1'b1, "R8 abort track", int'(track), 1);
      convert_and_check(12'h155);
   endtask

   task automatic test_shutdown();
      shdn_n = 1'b0;
      wait_cyc(10);
      chk(track == 1'b0, "R9 track", int'(track), 0);
      chk(dout_oe == 1'b0, "R9 oe", int'(dout_oe), 0);
      busy_cycles = 0;
      cs_n = 1'b0;
      wait_cyc(60);
      chk(busy_cycles == 0, "R9 no conversion", busy_cycles, 0);
      chk(dout_oe == 1'b0, "R9 cs ignored", int'(dout_oe), 0);
      cs_n = 1'b1;
      wait_cyc(10);
      shdn_n = 1'b1;
      wait_cyc(10);
      chk(track == 1'b1, "R10 wake track", int'(track), 1);
      convert_and_check(12'h3C7);
   endtask

   initial begin
      wait_cyc(5);
      rst_n = 1'b1;
      test_reset();
      convert_and_check(12'h000);
      convert_and_check(12'hFFF);
      convert_and_check(12'h800);
      convert_and_check(12'h7FF);
      convert_and_check(12'hA5C);
      convert_and_check(12'h001);
      test_abort();
      test_shutdown();
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule